// File: doc/BRIEF.md
# One-Bit Sigma-Delta Test-Signal Generator

This block turns a digital test waveform into an oversampled one-bit sigma-delta stream. The stream drives a precision analog stimulus circuit downstream. Two waveforms are available. The first is a continuous sine, used for distortion and common-mode measurements. The second is a single impulse, started by a trigger pin and used for synchronization and impulse-response work. A 24-bit gain input scales the waveform before it reaches a second-order error-feedback modulator. The stream advances one bit for each pulse of a bit-rate enable. Nominally that enable runs at 256 kHz, obtained by dividing a 2.048 MHz clock by eight.

The modulator input is held to a window of plus or minus one quarter of the quantizer span. As a result, the ones density stays between 25% and 75%, with 50% as the zero point. In impulse mode the gain is saturated to a fixed ceiling, because the impulse energy lies well above the sine band and the downstream low-power loop must stay stable. The sine is built from a 17-entry quarter-wave table that is mirrored into 64 points per period. Each point is held for `HOLD` bit periods; the default is 1024.

Top module: `tsg_bitstream_gen`

## Requirements
- R1: `bit_o` changes only at a clock edge where `bit_en_i` is high. While `bit_en_i` is low, `bit_o` holds its value.
- R2: With a zero waveform, the ones density is 50%. This holds in impulse mode with no trigger, and in either mode with a gain of 0. Over 1024 bits the count of ones is 512 within 8.
- R3: The modulator input u is clamped to the range -16384..16384. The ones density is 0.5 + u/65536, so it stays within 25%..75% for any gain. In sine mode with gain 0xFFFFFF, a sample of 19625 gives 75%.
- R4: The sine phase restarts at point 0 when reset is applied. Point k (0..63) is amplitude 27754·sin(2πk/64) and is held for 1024 bits. The point in use for the bit emitted after the E-th enable is point floor((E-2)/1024).
- R5: u = floor(sample·gain / 2^19), taken before the clamp. A gain of 0x04B8F2 gives full scale at the sine peak: point 16 gives 75% and point 48 gives 25%. A gain of 0x025C79 gives about 62.5% at a sample of 27754.
- R6: In impulse mode (`mode_i` = 1), a rising edge on `trig_i` while idle starts one impulse. The impulse is one sample period (1024 bits) of the full-scale sample 27754, followed by zero. Its waveform is 0 at all other times.
- R7: In impulse mode the gain is saturated to 0x0078E5. With gain 0xFFFFFF, an impulse adds about 25.6 ones above midscale, summed over the whole stream.
- R8: A rising edge on `trig_i` has no effect while an impulse is pending or in progress.
- R9: While `rst_ni` is low, `bit_o` is 0 and the modulator state is at midscale.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | Bit-rate enable, one pulse per output bit |
| mode_i | input | 1 | Waveform select: 0 sine, 1 impulse |
| gain_i | input | 24 | Unsigned waveform gain |
| trig_i | input | 1 | Impulse trigger, acts on its rising edge |
| bit_o | output | 1 | One-bit sigma-delta stream |

## Verification
From the ports, the hardest thing to reach is a chosen sine point or a live impulse, and then to read a density that belongs to it alone. The bench counts every enable it issues from reset. It places each density window in the middle of a known sample hold and changes the gain just before that window. To test retriggering, a second trigger edge is raised halfway through a running impulse. The ones count over a window that covers both edges must then match a single impulse's excess, not two.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  localparam int SMP_W  = 17;     // signed waveform sample width
  localparam int PH_W   = 6;      // 64 points per sine period
  localparam int A_FS   = 27754;  // full-scale sample amplitude

  typedef enum logic {WAVE_SINE = 1'b0, WAVE_IMPULSE = 1'b1} wave_e;

  // quarter-wave magnitude, j = 0..16 -> A_FS*sin(pi*j/32)
  function automatic logic signed [SMP_W-1:0] quarter_mag(input logic [4:0] j);
    case (j)
      5'd0:    quarter_mag = 17'sd0;
      5'd1:    quarter_mag = 17'sd2720;
      5'd2:    quarter_mag = 17'sd5415;
      5'd3:    quarter_mag = 17'sd8057;
      5'd4:    quarter_mag = 17'sd10621;
      5'd5:    quarter_mag = 17'sd13083;
      5'd6:    quarter_mag = 17'sd15419;
      5'd7:    quarter_mag = 17'sd17607;
      5'd8:    quarter_mag = 17'sd19625;
      5'd9:    quarter_mag = 17'sd21454;
      5'd10:   quarter_mag = 17'sd23077;
      5'd11:   quarter_mag = 17'sd24477;
      5'd12:   quarter_mag = 17'sd25641;
      5'd13:   quarter_mag = 17'sd26559;
      5'd14:   quarter_mag = 17'sd27221;
      5'd15:   quarter_mag = 17'sd27620;
      default: quarter_mag = 17'sd27754;
    endcase
  endfunction

  function automatic logic signed [SMP_W-1:0] sine_point(input logic [PH_W-1:0] k);
    logic [4:0] j;
    logic [4:0] jm;
    j  = {1'b0, k[3:0]};
    jm = 5'd16 - j;
    case (k[5:4])
      2'd0:    sine_point =  quarter_mag(j);
      2'd1:    sine_point =  quarter_mag(jm);
      2'd2:    sine_point = -quarter_mag(j);
      default: sine_point = -quarter_mag(jm);
    endcase
  endfunction
endpackage

// File: rtl/tsg_sequencer.sv
module tsg_sequencer
  import tsg_pkg::*;
#(
  parameter int HOLD = 1024
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bit_en_i,
  input  wave_e                   mode_i,
  input  logic                    trig_i,
  output logic signed [SMP_W-1:0] sample_o
);
  localparam int HW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [HW-1:0] LAST = HW'(HOLD - 1);

  logic [HW-1:0]   hold_q, hold_d;
  logic [PH_W-1:0] idx_q, idx_d;
  logic            trig_q;
  logic            pend_q, pend_d;
  logic            act_q, act_d;
  logic [HW-1:0]   icnt_q, icnt_d;
  logic            trig_rise;

  assign trig_rise = trig_i & ~trig_q;

  always_comb begin
    hold_d = hold_q;
    idx_d  = idx_q;
    pend_d = pend_q;
    act_d  = act_q;
    icnt_d = icnt_q;
    if (bit_en_i) begin
      if (hold_q == LAST) begin
        hold_d = '0;
        idx_d  = idx_q + 1'b1;
      end else begin
        hold_d = hold_q + 1'b1;
      end
      if (act_q) begin
        if (icnt_q == LAST) act_d = 1'b0;
        else                icnt_d = icnt_q + 1'b1;
      end else if (pend_q) begin
        pend_d = 1'b0;
        act_d  = 1'b1;
        icnt_d = '0;
      end
    end
    if (trig_rise && mode_i == WAVE_IMPULSE && !pend_q && !act_q)
      pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      idx_q  <= '0;
      trig_q <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      icnt_q <= '0;
    end else begin
      hold_q <= hold_d;
      idx_q  <= idx_d;
      trig_q <= trig_i;
      pend_q <= pend_d;
      act_q  <= act_d;
      icnt_q <= icnt_d;
    end
  end

  always_comb begin
    if (mode_i == WAVE_IMPULSE) sample_o = act_q ? SMP_W'(A_FS) : '0;
    else                        sample_o = sine_point(idx_q);
  end

  // R8: an edge during a running impulse does not restart its count
  a_r8_retrig_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && trig_rise && bit_en_i && icnt_q != LAST) |=> (act_q && icnt_q == $past(icnt_q) + 1'b1));
endmodule

// File: rtl/tsg_scaler.sv
module tsg_scaler
  import tsg_pkg::*;
#(
  parameter int          G_W   = 24,
  parameter int          U_W   = 16,
  parameter int          SHIFT = 19,
  parameter int          LIMIT = 16384,
  parameter logic [23:0] CAP   = 24'h0078E5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bit_en_i,
  input  wave_e                   mode_i,
  input  logic [G_W-1:0]          gain_i,
  input  logic signed [SMP_W-1:0] sample_i,
  output logic signed [U_W-1:0]   u_o
);
  localparam int P_W = SMP_W + G_W + 1;
  localparam logic signed [P_W-1:0] LIM_P   = P_W'(LIMIT);
  localparam logic signed [P_W-1:0] LIM_N   = -P_W'(LIMIT);
  localparam logic [G_W-1:0]        CAP_G   = G_W'(CAP);
  localparam int                    IMP_MAX = (A_FS * int'(CAP)) >>> SHIFT;

  logic [G_W-1:0]          g_eff;
  logic signed [P_W-1:0]   prod, scaled;
  logic signed [U_W-1:0]   u_d, u_q;

  always_comb begin
    g_eff = gain_i;
    if (mode_i == WAVE_IMPULSE && gain_i > CAP_G) g_eff = CAP_G;
    prod   = P_W'(sample_i) * $signed({1'b0, g_eff});
    scaled = prod >>> SHIFT;
    if (scaled > LIM_P)      u_d = U_W'(LIMIT);
    else if (scaled < LIM_N) u_d = -U_W'(LIMIT);
    else                     u_d = scaled[U_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       u_q <= '0;
    else if (bit_en_i) u_q <= u_d;
  end

  assign u_o = u_q;

  a_r3_density_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (u_q <= U_W'(LIMIT)) && (u_q >= -U_W'(LIMIT)));

  a_r7_impulse_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && mode_i == WAVE_IMPULSE) |=> (u_q <= U_W'(IMP_MAX) && u_q >= -U_W'(IMP_MAX)));
endmodule

// File: rtl/tsg_mod2.sv
module tsg_mod2 #(
  parameter int U_W = 16,
  parameter int E_W = 18
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bit_en_i,
  input  logic signed [U_W-1:0] u_i,
  output logic                  bit_o
);
  localparam int V_W = E_W + 3;
  localparam logic signed [V_W-1:0] QSTEP = V_W'(1 << (U_W - 1));
  localparam logic signed [V_W-1:0] EMAX  = V_W'((1 << (E_W - 1)) - 1);

  logic signed [E_W-1:0] e1_q, e2_q, e_d;
  logic signed [V_W-1:0] v, d;
  logic                  y, bit_q;

  always_comb begin
    v = V_W'(u_i) + (V_W'(e1_q) <<< 1) - V_W'(e2_q);
    y = ~v[V_W-1];
    d = y ? (v - QSTEP) : (v + QSTEP);
    if (d > EMAX)       e_d = EMAX[E_W-1:0];
    else if (d < -EMAX) e_d = -EMAX[E_W-1:0];
    else                e_d = d[E_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e1_q  <= '0;
      e2_q  <= '0;
      bit_q <= 1'b0;
    end else if (bit_en_i) begin
      e1_q  <= e_d;
      e2_q  <= e1_q;
      bit_q <= y;
    end
  end

  assign bit_o = bit_q;

  a_r1_bit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(bit_o));
endmodule

// File: rtl/tsg_bitstream_gen.sv
module tsg_bitstream_gen
  import tsg_pkg::*;
#(
  parameter int          HOLD  = 1024,
  parameter int          G_W   = 24,
  parameter int          U_W   = 16,
  parameter int          E_W   = 18,
  parameter int          SHIFT = 19,
  parameter int          LIMIT = 16384,
  parameter logic [23:0] CAP   = 24'h0078E5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bit_en_i,
  input  logic           mode_i,
  input  logic [G_W-1:0] gain_i,
  input  logic           trig_i,
  output logic           bit_o
);
  wave_e                   mode;
  logic signed [SMP_W-1:0] sample;
  logic signed [U_W-1:0]   u;

  assign mode = wave_e'(mode_i);

  tsg_sequencer #(.HOLD(HOLD)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i),
    .mode_i(mode), .trig_i(trig_i), .sample_o(sample));

  tsg_scaler #(.G_W(G_W), .U_W(U_W), .SHIFT(SHIFT), .LIMIT(LIMIT), .CAP(CAP)) u_scl (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .mode_i(mode),
    .gain_i(gain_i), .sample_i(sample), .u_o(u));

  tsg_mod2 #(.U_W(U_W), .E_W(E_W)) u_mod (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .u_i(u), .bit_o(bit_o));

  // R9: output at midscale start while reset is held
  a_r9_reset_low: assert property (@(posedge clk_i) !rst_ni |-> !bit_o);
endmodule

// File: tb/tb_tsg_bitstream_gen.sv
`timescale 1ns/1ps
module tb_tsg_bitstream_gen;
  localparam logic [23:0] G_FS   = 24'h04B8F2;
  localparam logic [23:0] G_HALF = 24'h025C79;
  localparam logic [23:0] G_MAX  = 24'hFFFFFF;
  localparam int TOL = 8;

  typedef struct packed {
    logic [31:0] idx;
    logic [23:0] gain;
    logic [31:0] exp_ones;
  } vec_t;

  // sine point, gain, expected ones over 896 bits
  localparam vec_t VEC [8] = '{
    '{32'd0,  G_FS,   32'd448},
    '{32'd8,  G_FS,   32'd606},
    '{32'd16, G_FS,   32'd672},
    '{32'd24, G_MAX,  32'd672},
    '{32'd32, G_FS,   32'd448},
    '{32'd40, G_HALF, 32'd369},
    '{32'd48, G_FS,   32'd224},
    '{32'd56, 24'd0,  32'd448}
  };

  logic        clk = 1'b0;
  logic        rst_n, bit_en, mode, trig;
  logic [23:0] gain;
  logic        bit_o;

  int total = 0;
  int bad   = 0;
  int ecnt  = 0;
  int ones  = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  tsg_bitstream_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .mode_i(mode),
    .gain_i(gain), .trig_i(trig), .bit_o(bit_o));

  task automatic check(input string req, input int act, input int exp, input int tol);
    total++;
    if (act > exp + tol || act < exp - tol) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  task automatic run(input int n, input bit count);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      ecnt++;
      if (count) ones += int'(bit_o);
    end
  endtask

  task automatic run_to(input int e);
    if (ecnt < e) run(e - ecnt, 1'b0);
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    bit_en = 1'b0;
    rst_n  = 1'b0;
    trig   = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 bit_o in reset", int'(bit_o), 0, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R9 bit_o after reset", int'(bit_o), 0, 0);
    bit_en = 1'b1;
    ecnt   = 0;
  endtask

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; mode = 1'b1; trig = 1'b0; gain = 24'd0;

    // R2: zero waveform, impulse mode, no trigger
    do_reset();
    run_to(63);
    ones = 0; run(1024, 1'b1);
    check("R2 zero density", ones, 512, TOL);

    // R1: output frozen while the enable is low
    begin
      logic held;
      bit   flip;
      held = bit_o; flip = 1'b0;
      bit_en = 1'b0;
      for (int i = 0; i < 20; i++) begin
        @(posedge clk); #1;
        if (bit_o !== held) flip = 1'b1;
      end
      check("R1 hold without enable", int'(flip), 0, 0);
      bit_en = 1'b1;
    end

    // R4 R5 R3: sine table walk, 896-bit windows mid-hold
    mode = 1'b0; gain = G_FS;
    do_reset();
    for (int v = 0; v < 8; v++) begin
      int base;
      base = int'(VEC[v].idx) * 1024;
      run_to(base + 8);
      gain = VEC[v].gain;
      run_to(base + 63);
      ones = 0; run(896, 1'b1);
      check($sformatf("R4/R5/R3 sine point %0d", VEC[v].idx), ones, int'(VEC[v].exp_ones), TOL);
    end

    // R6 R7: impulse at saturated gain
    mode = 1'b1; gain = G_MAX;
    do_reset();
    run(100, 1'b0);
    trig = 1'b1;
    ones = 0; run(2048, 1'b1);
    trig = 1'b0;
    check("R6/R7 impulse excess capped", ones, 1050, TOL);
    ones = 0; run(1024, 1'b1);
    check("R6 return to zero", ones, 512, TOL);

    // R8: second edge mid-impulse is ignored
    run(50, 1'b0);
    trig = 1'b1;
    ones = 0; run(150, 1'b1);
    trig = 1'b0;
    run(150, 1'b1);
    trig = 1'b1;
    run(20, 1'b1);
    trig = 1'b0;
    run(4096 - 320, 1'b1);
    check("R8 retrigger ignored", ones, 2074, TOL);

    // R2: zero gain in sine mode
    mode = 1'b0; gain = 24'd0;
    do_reset();
    run_to(63);
    ones = 0; run(1024, 1'b1);
    check("R2 zero gain sine", ones, 512, TOL);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #950000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule